// File: doc/BRIEF.md
# SD SPI-Mode Command Framer

This block sends one SD/MMC command over an SPI link in SPI mode and collects the card's one-byte status reply. A command enters as a 6-bit index and a 32-bit argument on a valid/ready port. The block then runs a sequence of byte exchanges with an external SPI bit shifter. Each exchange offers one byte on a valid/ready transmit port. The shifter later returns the byte it clocked in on a one-cycle receive strobe. Only one exchange is ever outstanding.

Seven bytes go out for each command. First comes an all-ones filler byte. Next is the command byte, which is the index with its top two bits set to binary 01. Then the argument follows, most significant byte first. Last is a checksum byte, whose CRC7 is accumulated while the command and argument bytes leave. After the frame, the block keeps sending 0xFF and watches the returned bytes for the status byte, up to a bounded number of polls. The bench uses this reply to find that byte. Two commands, index 8 and index 58, also carry a 4-byte trailer, which the block reads and assembles.

The response port has no back-pressure. `rsp_valid` pulses for one cycle when a command completes. The result outputs then hold their values until the next command is accepted. A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole time `busy` is high.

Top module: `sdcmd_framer`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle until completion. While `busy` is high, `cmd_ready` is low, and strobes or changes on `cmd_index`/`cmd_arg` have no effect on the transmitted frame.
- R2: When `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. After a transmit handshake, `tx_valid` stays low until `rx_valid` returns that exchange's byte, so at most one exchange is outstanding.
- R3: The frame is 7 bytes, in this order: 0xFF, then 0x40 OR the index, then argument bits 31:24, 23:16, 15:8 and 7:0, then the checksum byte.
- R4: The checksum byte is {crc7, 1}. The crc7 uses the polynomial x^7+x^3+1, starts from zero, and is taken MSB first over the command byte and the four argument bytes. For index 0 with argument 0, the checksum byte is 0x95.
- R5: After the frame, the block sends 0xFF up to POLL_MAX (8) times. The byte returned by the first poll is never accepted. The first later byte with bit 7 equal to 0 is accepted as the status, and polling stops there.
- R6: If no byte is accepted, `rsp_r1` reports the last polled byte and `rsp_timeout` is 1. `rsp_noresp` is 1 exactly when that byte is 0xFF.
- R7: For index 8 or 58, and only when a status byte was accepted, four more 0xFF exchanges follow. Their replies form `rsp_data`, with the first reply placed in bits 31:24. In every other case, `rsp_data` is 0 and no extra exchange occurs.
- R8: `rsp_crc_err` is 1 when an accepted status has bit 3 set. `rsp_cmd_err` is 1 when an accepted status has any of bits 7:1 set. Both are 0 on timeout.
- R9: `rsp_valid` pulses for exactly one cycle, in the first cycle where `busy` is low. The result outputs hold their values until the next accepted command.
- R10: After reset, `busy`, `tx_valid`, `rsp_valid`, all flags, `rsp_r1` and `rsp_data` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | Command in progress |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_data | output | 8 | Byte to shift out |
| rx_valid | input | 1 | Shifter returns the exchanged byte |
| rx_data | input | 8 | Byte shifted in |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_r1 | output | 8 | Status byte, or last polled byte on timeout |
| rsp_data | output | 32 | Trailer word, first byte most significant |
| rsp_timeout | output | 1 | No status byte accepted |
| rsp_noresp | output | 1 | Timeout with last byte 0xFF |
| rsp_crc_err | output | 1 | Accepted status reports a checksum error |
| rsp_cmd_err | output | 1 | Accepted status reports any error |

## Verification
The bench targets several boundary cases:
- A first polled byte of 0x00 must be skipped. A design that accepts it would report 0x00 and would read the wrong trailer bytes.
- A status that arrives on the eighth poll must still be taken, while one that never arrives must yield the last byte. An off-by-one poll counter either misses the status or sends a ninth poll.
- A timeout on index 8 must skip the trailer. A design that reads the trailer anyway would make four extra exchanges.
- Command inputs are changed during a strobe while busy. A design without a latched copy would corrupt the frame, and one that accepts while busy would start a second frame.
- Transmit stalls and variable return latency are applied. These expose a design that drops `tx_data` while stalled or starts a new exchange before the previous byte has returned.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sdf_state_e;

  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_POLL  = 2'd1,
    PH_TRAIL = 2'd2
  } sdf_phase_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sdf_crc7.sv
module sdf_crc7 #(
  parameter int         DW   = 8,
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [6:0]    crc
);
  logic [6:0] crc_q;
  logic [6:0] crc_d;

  always_comb begin
    logic fb;
    crc_d = crc_q;
    for (int i = DW - 1; i >= 0; i--) begin
      fb    = crc_d[6] ^ din[i];
      crc_d = {crc_d[5:0], 1'b0};
      if (fb) crc_d = crc_d ^ POLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (upd) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int FRAME_LEN = 7,
  parameter int POLL_MAX  = 8,
  parameter int TRAIL_LEN = 4,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          trail_en,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic          rx_msb,
  output logic          busy,
  output logic          tx_valid,
  output sdf_phase_e    phase,
  output logic [CW-1:0] cnt,
  output logic          crc_upd,
  output logic          poll_take,
  output logic          poll_hit,
  output logic          trail_take,
  output logic          finish
);
  sdf_state_e    state_q, state_d;
  sdf_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rx_take, frame_last, poll_last, trail_last;

  always_comb begin
    rx_take    = (state_q == ST_WAIT) && rx_valid;
    frame_last = (cnt_q == CW'(FRAME_LEN - 1));
    poll_last  = (cnt_q == CW'(POLL_MAX - 1));
    trail_last = (cnt_q == CW'(TRAIL_LEN - 1));
    poll_take  = rx_take && (phase_q == PH_POLL);
    poll_hit   = poll_take && (cnt_q != '0) && !rx_msb;
    trail_take = rx_take && (phase_q == PH_TRAIL);
    finish     = (poll_take && (poll_hit ? !trail_en : poll_last)) ||
                 (trail_take && trail_last);
    crc_upd    = (state_q == ST_ISSUE) && tx_ready && (phase_q == PH_FRAME) &&
                 (cnt_q >= CW'(1)) && (cnt_q <= CW'(FRAME_LEN - 2));
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ISSUE;
          phase_d = PH_FRAME;
          cnt_d   = '0;
        end
      end
      ST_ISSUE: begin
        if (tx_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rx_valid) begin
          state_d = ST_ISSUE;
          cnt_d   = cnt_q + CW'(1);
          unique case (phase_q)
            PH_FRAME: if (frame_last) begin
              phase_d = PH_POLL;
              cnt_d   = '0;
            end
            PH_POLL: if (poll_hit) begin
              phase_d = PH_TRAIL;
              cnt_d   = '0;
            end
            default: ;
          endcase
          if (finish) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FRAME;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign tx_valid = (state_q == ST_ISSUE);
  assign phase    = phase_q;
  assign cnt      = cnt_q;
endmodule

// File: rtl/sdf_txmux.sv
module sdf_txmux
  import sdf_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ARG_W     = 32,
  parameter int FRAME_LEN = 7,
  parameter int CW        = 3
) (
  input  sdf_phase_e    phase,
  input  logic [CW-1:0] cnt,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  input  logic [6:0]    crc,
  output logic [7:0]    txd
);
  localparam int ARG_BYTES = ARG_W / 8;

  always_comb begin
    txd = FILL_BYTE;
    if (phase == PH_FRAME) begin
      if (cnt == CW'(1)) begin
        txd = 8'h40 | 8'(idx);
      end else if (cnt == CW'(FRAME_LEN - 1)) begin
        txd = {crc, 1'b1};
      end else begin
        for (int k = 0; k < ARG_BYTES; k++) begin
          if (cnt == CW'(k + 2)) txd = arg[ARG_W-1-8*k -: 8];
        end
      end
    end
  end
endmodule

// File: rtl/sdf_resp.sv
module sdf_resp #(
  parameter int TRAIL_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   poll_take,
  input  logic                   poll_hit,
  input  logic                   trail_take,
  input  logic                   finish,
  input  logic [7:0]             rx_data,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_r1,
  output logic [TRAIL_LEN*8-1:0] rsp_data,
  output logic                   rsp_timeout,
  output logic                   rsp_noresp,
  output logic                   rsp_crc_err,
  output logic                   rsp_cmd_err
);
  localparam int TW = TRAIL_LEN * 8;

  logic [7:0]    r1_q;
  logic [TW-1:0] data_q;
  logic          hit_q, done_q, valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q    <= '0;
      data_q  <= '0;
      hit_q   <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (start) begin
        r1_q   <= '0;
        data_q <= '0;
        hit_q  <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (poll_take)  r1_q   <= rx_data;
        if (poll_hit)   hit_q  <= 1'b1;
        if (trail_take) data_q <= {data_q[TW-9:0], rx_data};
        if (finish)     done_q <= 1'b1;
      end
    end
  end

  assign rsp_valid   = valid_q;
  assign rsp_r1      = r1_q;
  assign rsp_data    = data_q;
  assign rsp_timeout = done_q && !hit_q;
  assign rsp_noresp  = done_q && !hit_q && (r1_q == 8'hFF);
  assign rsp_crc_err = done_q && hit_q && r1_q[3];
  assign rsp_cmd_err = done_q && hit_q && (r1_q[7:1] != '0);
endmodule

// File: rtl/sdcmd_framer.sv
module sdcmd_framer
  import sdf_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int POLL_MAX    = 8,
  parameter int TRAIL_LEN   = 4,
  parameter int TRAIL_CMD_A = 8,
  parameter int TRAIL_CMD_B = 58
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [IDX_W-1:0]       cmd_index,
  input  logic [ARG_W-1:0]       cmd_arg,
  output logic                   busy,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_r1,
  output logic [TRAIL_LEN*8-1:0] rsp_data,
  output logic                   rsp_timeout,
  output logic                   rsp_noresp,
  output logic                   rsp_crc_err,
  output logic                   rsp_cmd_err
);
  localparam int FRAME_LEN = 2 + ARG_W / 8 + 1;
  localparam int CNT_MAX   = max3(FRAME_LEN, POLL_MAX, TRAIL_LEN);
  localparam int CW        = $clog2(CNT_MAX);

  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;
  logic             start, trail_en, crc_upd;
  logic             poll_take, poll_hit, trail_take, finish;
  logic [6:0]       crc;
  logic [CW-1:0]    cnt;
  sdf_phase_e       phase;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && !busy;
  assign trail_en  = (idx_q == IDX_W'(TRAIL_CMD_A)) || (idx_q == IDX_W'(TRAIL_CMD_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      arg_q <= '0;
    end else if (start) begin
      idx_q <= cmd_index;
      arg_q <= cmd_arg;
    end
  end

  sdf_ctrl #(
    .FRAME_LEN(FRAME_LEN), .POLL_MAX(POLL_MAX), .TRAIL_LEN(TRAIL_LEN), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .trail_en(trail_en),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_msb(rx_data[7]),
    .busy(busy), .tx_valid(tx_valid), .phase(phase), .cnt(cnt),
    .crc_upd(crc_upd), .poll_take(poll_take), .poll_hit(poll_hit),
    .trail_take(trail_take), .finish(finish)
  );

  sdf_crc7 #(.DW(8), .POLY(7'h09)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start), .upd(crc_upd),
    .din(tx_data), .crc(crc)
  );

  sdf_txmux #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .FRAME_LEN(FRAME_LEN), .CW(CW)
  ) u_txmux (
    .phase(phase), .cnt(cnt), .idx(idx_q), .arg(arg_q), .crc(crc), .txd(tx_data)
  );

  sdf_resp #(.TRAIL_LEN(TRAIL_LEN)) u_resp (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_take(poll_take),
    .poll_hit(poll_hit), .trail_take(trail_take), .finish(finish),
    .rx_data(rx_data), .rsp_valid(rsp_valid), .rsp_r1(rsp_r1),
    .rsp_data(rsp_data), .rsp_timeout(rsp_timeout), .rsp_noresp(rsp_noresp),
    .rsp_crc_err(rsp_crc_err), .rsp_cmd_err(rsp_cmd_err)
  );
endmodule

// File: rtl/sdcmd_framer_chk.sv
module sdcmd_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rsp_valid,
  input logic [7:0] rsp_r1,
  input logic       rsp_timeout,
  input logic       rsp_noresp,
  input logic       rsp_crc_err,
  input logic       rsp_cmd_err
);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_hold_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  p_lead_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (tx_valid && tx_data == 8'hFF));

  p_noresp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_noresp |-> (rsp_timeout && rsp_r1 == 8'hFF));

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> (!rsp_crc_err && !rsp_cmd_err));

  p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rsp_r1));
endmodule

bind sdcmd_framer sdcmd_framer_chk u_chk (.*);

// File: tb/sdcmd_framer_tb.sv
`timescale 1ns/1ps
module sdcmd_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        busy, tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rsp_valid;
  logic [7:0]  rsp_r1;
  logic [31:0] rsp_data;
  logic        rsp_timeout, rsp_noresp, rsp_crc_err, rsp_cmd_err;

  always #2.5 clk = ~clk;

  sdcmd_framer u_dut (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0]  frame_exp [7];
  logic [7:0]  reply_q [$];
  int          xchg_n = 0;
  int          exp_total = 0;
  logic [7:0]  e_r1;
  logic [31:0] e_data;
  bit          e_to, e_nr, e_crc, e_ce;
  int          lat = 0;
  logic [7:0]  stall = 8'h00;
  int          cyc = 0;
  bit          model_busy = 0;
  bit          ready_prev = 1;
  int          done_cnt = 0;
  int          rx_cnt = 0;
  logic [7:0]  pend = 8'hFF;
  logic [7:0]  cap_crc = 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] reply_at(input int p);
    return (p < reply_q.size()) ? reply_q[p] : 8'hFF;
  endfunction

  function automatic logic [7:0] ref_crc_byte(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] bits;
    int r;
    int fb;
    bits = {2'b01, idx, arg};
    r = 0;
    for (int i = 39; i >= 0; i--) begin
      fb = ((r >> 6) & 1) ^ int'(bits[i]);
      r = (r << 1) & 127;
      if (fb != 0) r = r ^ 9;
    end
    return {r[6:0], 1'b1};
  endfunction

  // behavioural card, shifter and reference, compared every clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      rx_valid = 1'b0;
      if (rst_n) begin
        if (cmd_valid && ready_prev) model_busy = 1;
        ready_prev = cmd_ready;
        if (rsp_valid) begin
          chk(rsp_r1 == e_r1, e_to ? "R6" : "R5", "status byte", rsp_r1, e_r1);
          chk(rsp_timeout == e_to, "R6", "timeout flag", rsp_timeout, e_to);
          chk(rsp_noresp == e_nr, "R6", "noresp flag", rsp_noresp, e_nr);
          chk(rsp_crc_err == e_crc, "R8", "crc error flag", rsp_crc_err, e_crc);
          chk(rsp_cmd_err == e_ce, "R8", "command error flag", rsp_cmd_err, e_ce);
          chk(rsp_data == e_data, "R7", "trailer word", rsp_data, e_data);
          chk(xchg_n == exp_total, "R7", "exchange count", xchg_n, exp_total);
          model_busy = 0;
          done_cnt++;
        end
        if (busy != model_busy) chk(0, "R9", "busy vs model", busy, model_busy);
        if (tx_valid && (!model_busy || rx_cnt > 0))
          chk(0, "R2", "tx offered while not allowed", tx_valid, 0);
        tx_ready = !stall[cyc % 8];
        if (tx_valid && tx_ready) begin
          if (xchg_n < 7) begin
            chk(tx_data == frame_exp[xchg_n], "R3", "frame byte", tx_data, frame_exp[xchg_n]);
            if (xchg_n == 6) cap_crc = tx_data;
            pend = 8'hFF;
          end else begin
            chk(tx_data == 8'hFF, "R5", "poll/trailer fill byte", tx_data, 8'hFF);
            pend = reply_at(xchg_n - 7);
          end
          xchg_n++;
          rx_cnt = lat + 1;
        end else if (rx_cnt > 0) begin
          rx_cnt--;
          if (rx_cnt == 0) begin
            rx_valid = 1'b1;
            rx_data  = pend;
          end
        end
      end
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input int latency, input logic [7:0] stall_pat, input bit poke);
    bit acc;
    logic [7:0] b;
    int n;
    int start_done;
    frame_exp[0] = 8'hFF;
    frame_exp[1] = {2'b01, idx};
    frame_exp[2] = arg[31:24];
    frame_exp[3] = arg[23:16];
    frame_exp[4] = arg[15:8];
    frame_exp[5] = arg[7:0];
    frame_exp[6] = ref_crc_byte(idx, arg);
    acc = 0;
    b = 8'hFF;
    n = 0;
    for (int p = 0; p < 8; p++) begin
      b = reply_at(p);
      n = p + 1;
      if (p > 0 && !b[7]) begin
        acc = 1;
        break;
      end
    end
    e_r1 = b;
    e_to = !acc;
    e_nr = !acc && (b == 8'hFF);
    e_crc = acc && b[3];
    e_ce = acc && (b[7:1] != 0);
    e_data = 0;
    exp_total = 7 + n;
    if (acc && (idx == 6'd8 || idx == 6'd58)) begin
      for (int t = 0; t < 4; t++) e_data = {e_data[23:0], reply_at(n + t)};
      exp_total += 4;
    end
    lat = latency;
    stall = stall_pat;
    xchg_n = 0;
    start_done = done_cnt;
    @(negedge clk);
    cmd_index = idx;
    cmd_arg = arg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_index = ~idx;
    cmd_arg = ~arg;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!cmd_ready, "R1", "cmd_ready low while busy", cmd_ready, 0);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done_cnt == start_done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rsp_r1 == e_r1 && !busy && cmd_ready, "R9", "result held after completion", rsp_r1, e_r1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !tx_valid && !rsp_valid && cmd_ready, "R10", "idle after reset",
        {busy, tx_valid, rsp_valid, cmd_ready}, 4'b0001);
    chk(rsp_r1 == 0 && rsp_data == 0, "R10", "result zero after reset", rsp_r1, 0);
    chk(!rsp_timeout && !rsp_noresp && !rsp_crc_err && !rsp_cmd_err, "R10", "flags clear after reset",
        {rsp_timeout, rsp_noresp, rsp_crc_err, rsp_cmd_err}, 0);

    reply_q = '{8'hFF, 8'h01};
    run_cmd(6'd0, 32'h0, 0, 8'h00, 0);
    chk(cap_crc == 8'h95, "R4", "checksum of index 0 arg 0", cap_crc, 8'h95);

    reply_q = '{8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h01, 8'hAA};
    run_cmd(6'd8, 32'h0000_01AA, 2, 8'h5A, 0);

    reply_q = '{8'h00, 8'h00, 8'hC0, 8'hFF, 8'h80, 8'h00};
    run_cmd(6'd58, 32'h0, 1, 8'h00, 0);

    reply_q = '{};
    run_cmd(6'd1, 32'h4000_0000, 0, 8'h00, 0);

    reply_q = '{8'h00, 8'h80, 8'h81, 8'h90, 8'hC4, 8'hFF, 8'hEE, 8'h9F};
    run_cmd(6'd16, 32'd512, 1, 8'h11, 0);

    reply_q = '{8'hFF, 8'hFF, 8'hFF, 8'h0D};
    run_cmd(6'd17, 32'h1234_5678, 3, 8'h24, 0);

    reply_q = '{8'hFF, 8'h04};
    run_cmd(6'd55, 32'hDEAD_BEEF, 2, 8'h00, 1);

    reply_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    run_cmd(6'd41, 32'h4000_0000, 0, 8'h81, 0);

    reply_q = '{};
    run_cmd(6'd8, 32'h0000_01AA, 0, 8'h00, 0);

    reply_q = '{8'hFF, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44};
    run_cmd(6'd58, 32'h0, 1, 8'h42, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=%h expected=%h", done_cnt, 10);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule